// File: doc/BRIEF.md
# Three-phase PWM timebase with boundary-synchronized reload

The block is a free-running period counter for a three-phase inverter. The counter is 11 bits wide by default. It runs from zero up to a programmable last value and then wraps. One cycle before the wrap it raises an early flag. In the cycle after that flag it shows a count of zero and raises a one-cycle period-start pulse. Each phase has a compare value and separate enables for the high-side and low-side switches. The compare output of a phase is high while the count is below the active compare value.

New compare values and enables arrive on a valid/ready stream and land in a single shadow slot. The shadow is copied into the active registers only in a cycle where the early flag is high. An update therefore takes effect at the start of a period and never in the middle of one.

Back-pressure works as follows. `cfg_ready_o` is high only while the shadow slot is empty. A transfer occurs on a clock edge where both `cfg_valid_i` and `cfg_ready_o` are high. After a transfer the slot stays full, and ready stays low, until the next early cycle moves the slot into the active registers. At most one update is accepted per period. A beat offered while ready is low is not captured. The producer must hold it until ready returns.

Top module: `pwm_timebase`

## Requirements
- R1: While reset is asserted and right after it is released, count is 0, the period-start pulse is low, the config stream is ready, and all six phase outputs are low (active compare values are 0 and all enables are 0).
- R2: The early flag is high in exactly those cycles where the count is greater than or equal to (period_i − 1), computed modulo 2^W. With a steady period_i of P ≥ 1, the count therefore runs 0 to P−1 and the early flag is high at count P−1.
- R3: In the cycle after an early cycle, the count is 0 and the period-start pulse is high. The pulse lasts one cycle.
- R4: In every cycle that does not follow an early cycle, the count is one more than in the cycle before, and the period-start pulse is low.
- R5: A config beat is taken on a clock edge where cfg_valid_i and cfg_ready_o are both high. Ready then stays low until the slot has been moved into the active registers.
- R6: The active compare values and enables change only on the edge that ends an early cycle, and only if the slot is full. A beat accepted earlier in the period first shows at the phase outputs in the cycle where the count is 0.
- R7: A beat offered while ready is low is ignored. The active set loaded at the next boundary is the beat accepted before it.
- R8: For each phase p, the compare value sits at cfg_match_i bits [p*W +: W], and enable bit p belongs to phase p. The high-side output is en_hi[p] AND (count < match[p]). The low-side output is en_lo[p] AND (count ≥ match[p]). A match of 0 keeps the high-side output low for the whole period. A match ≥ P keeps it high for the whole period.
- R9: A period_i of 0 gives a full period of 2^W cycles: the early flag rises at count 2^W − 1.
- R10: If period_i is lowered so that the current count is already at or past the new (period_i − 1), the early flag is high at once and the counter wraps on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | W (11) | Period length in cycles; 0 means 2^W |
| cfg_valid_i | input | 1 | Config beat offered |
| cfg_ready_o | output | 1 | Shadow slot empty, beat can be taken |
| cfg_match_i | input | 3*W (33) | Compare values, phase p at bits [p*W +: W] |
| cfg_en_hi_i | input | 3 | High-side enables, bit p for phase p |
| cfg_en_lo_i | input | 3 | Low-side enables, bit p for phase p |
| count_o | output | W (11) | Current count |
| early_o | output | 1 | Last cycle of the period |
| sync_o | output | 1 | First cycle of the period |
| pwm_hi_o | output | 3 | High-side compare outputs |
| pwm_lo_o | output | 3 | Low-side compare outputs |

## Verification
A corrupted counter shows on count_o, early_o and sync_o in the very next cycle. It appears as a skipped or repeated value, a pulse that comes at the wrong count, or a period whose length differs from period_i. A fault in the shadow slot shows on cfg_ready_o in the cycle after a handshake. It shows on the phase outputs only at the next count of 0: either an update that does not arrive, a stale beat that arrives, or a change in the middle of a period. The bench therefore sweeps each output over a full period after every reload, and it checks the outputs in the cycles before the boundary while an update is pending.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;
  localparam int unsigned CNT_W_DEF  = 11;
  localparam int unsigned PHASES_DEF = 3;
endpackage

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] count_o,
  output logic         early_o,
  output logic         sync_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] last_val;
  logic         sync_q;

  // the last count of the period; period 0 wraps to the all-ones value
  assign last_val = period_i - W'(1);
  assign early_o  = (cnt_q >= last_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      sync_q <= early_o;
      if (early_o) cnt_q <= '0;
      else         cnt_q <= cnt_q + W'(1);
    end
  end

  assign count_o = cnt_q;
  assign sync_o  = sync_q;
endmodule

// File: rtl/pwm_tb_shadow.sv
module pwm_tb_shadow #(
  parameter int unsigned W = 11,
  parameter int unsigned N = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [N*W-1:0] in_match_i,
  input  logic [N-1:0]   in_en_hi_i,
  input  logic [N-1:0]   in_en_lo_i,
  input  logic           load_i,
  output logic [N*W-1:0] act_match_o,
  output logic [N-1:0]   act_en_hi_o,
  output logic [N-1:0]   act_en_lo_o
);
  logic           full_q;
  logic [N*W-1:0] sh_match_q;
  logic [N-1:0]   sh_hi_q;
  logic [N-1:0]   sh_lo_q;
  logic [N*W-1:0] ac_match_q;
  logic [N-1:0]   ac_hi_q;
  logic [N-1:0]   ac_lo_q;
  logic           take;
  logic           move;

  assign in_ready_o = !full_q;
  assign take       = in_valid_i && !full_q;
  assign move       = load_i && full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q     <= 1'b0;
      sh_match_q <= '0;
      sh_hi_q    <= '0;
      sh_lo_q    <= '0;
    end else if (take) begin
      full_q     <= 1'b1;
      sh_match_q <= in_match_i;
      sh_hi_q    <= in_en_hi_i;
      sh_lo_q    <= in_en_lo_i;
    end else if (move) begin
      full_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_match_q <= '0;
      ac_hi_q    <= '0;
      ac_lo_q    <= '0;
    end else if (move) begin
      ac_match_q <= sh_match_q;
      ac_hi_q    <= sh_hi_q;
      ac_lo_q    <= sh_lo_q;
    end
  end

  assign act_match_o = ac_match_q;
  assign act_en_hi_o = ac_hi_q;
  assign act_en_lo_o = ac_lo_q;
endmodule

// File: rtl/pwm_tb_phase.sv
module pwm_tb_phase #(
  parameter int unsigned W = 11
) (
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] match_i,
  input  logic         en_hi_i,
  input  logic         en_lo_i,
  output logic         hi_o,
  output logic         lo_o
);
  logic below;

  assign below = (count_i < match_i);
  assign hi_o  = en_hi_i && below;
  assign lo_o  = en_lo_i && !below;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter int unsigned W = CNT_W_DEF,
  parameter int unsigned N = PHASES_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   period_i,
  input  logic           cfg_valid_i,
  output logic           cfg_ready_o,
  input  logic [N*W-1:0] cfg_match_i,
  input  logic [N-1:0]   cfg_en_hi_i,
  input  logic [N-1:0]   cfg_en_lo_i,
  output logic [W-1:0]   count_o,
  output logic           early_o,
  output logic           sync_o,
  output logic [N-1:0]   pwm_hi_o,
  output logic [N-1:0]   pwm_lo_o
);
  logic [W-1:0]   cnt;
  logic           early;
  logic [N*W-1:0] act_match;
  logic [N-1:0]   act_hi;
  logic [N-1:0]   act_lo;

  pwm_tb_counter #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (period_i),
    .count_o  (cnt),
    .early_o  (early),
    .sync_o   (sync_o)
  );

  pwm_tb_shadow #(.W(W), .N(N)) u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (cfg_valid_i),
    .in_ready_o  (cfg_ready_o),
    .in_match_i  (cfg_match_i),
    .in_en_hi_i  (cfg_en_hi_i),
    .in_en_lo_i  (cfg_en_lo_i),
    .load_i      (early),
    .act_match_o (act_match),
    .act_en_hi_o (act_hi),
    .act_en_lo_o (act_lo)
  );

  for (genvar p = 0; p < N; p++) begin : g_phase
    pwm_tb_phase #(.W(W)) u_ph (
      .count_i (cnt),
      .match_i (act_match[p*W +: W]),
      .en_hi_i (act_hi[p]),
      .en_lo_i (act_lo[p]),
      .hi_o    (pwm_hi_o[p]),
      .lo_o    (pwm_lo_o[p])
    );
  end

  assign count_o = cnt;
  assign early_o = early;
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int unsigned W = 11,
  parameter int unsigned N = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cfg_valid_i,
  input logic           cfg_ready_o,
  input logic [W-1:0]   count_o,
  input logic           early_o,
  input logic           sync_o,
  input logic [N-1:0]   pwm_hi_o,
  input logic [N-1:0]   pwm_lo_o,
  input logic [N*W-1:0] act_match
);
  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o |=> (count_o == '0) && sync_o);

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !early_o |=> (count_o == $past(count_o) + W'(1)) && !sync_o);

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_valid_i && cfg_ready_o) |=> !cfg_ready_o);

  assert_midperiod_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !early_o |=> $stable(act_match));

  assert_sides_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_hi_o & pwm_lo_o) == '0);
endmodule

bind pwm_timebase pwm_timebase_chk #(.W(W), .N(N)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_valid_i (cfg_valid_i),
  .cfg_ready_o (cfg_ready_o),
  .count_o     (count_o),
  .early_o     (early_o),
  .sync_o      (sync_o),
  .pwm_hi_o    (pwm_hi_o),
  .pwm_lo_o    (pwm_lo_o),
  .act_match   (act_match)
);

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;
  localparam int W = 11;
  localparam int N = 3;

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic [W-1:0]   period_i;
  logic           cfg_valid_i;
  logic           cfg_ready_o;
  logic [N*W-1:0] cfg_match_i;
  logic [N-1:0]   cfg_en_hi_i;
  logic [N-1:0]   cfg_en_lo_i;
  logic [W-1:0]   count_o;
  logic           early_o;
  logic           sync_o;
  logic [N-1:0]   pwm_hi_o;
  logic [N-1:0]   pwm_lo_o;

  int total = 0;
  int bad   = 0;

  int exp_m [N] = '{3, 0, 10};
  logic [N-1:0] exp_hi_en = 3'b111;
  logic [N-1:0] exp_lo_en = 3'b101;

  always #5 clk_i = ~clk_i;

  pwm_timebase u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_i(period_i),
    .cfg_valid_i(cfg_valid_i), .cfg_ready_o(cfg_ready_o),
    .cfg_match_i(cfg_match_i), .cfg_en_hi_i(cfg_en_hi_i), .cfg_en_lo_i(cfg_en_lo_i),
    .count_o(count_o), .early_o(early_o), .sync_o(sync_o),
    .pwm_hi_o(pwm_hi_o), .pwm_lo_o(pwm_lo_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R1 count", int'(count_o), 0);
    chk("R1 sync", int'(sync_o), 0);
    chk("R1 ready", int'(cfg_ready_o), 1);
    chk("R1 hi", int'(pwm_hi_o), 0);
    chk("R1 lo", int'(pwm_lo_o), 0);
  endtask

  task automatic t_count();
    for (int k = 1; k <= 9; k++) begin
      step();
      chk("R4 count", int'(count_o), k);
      chk("R4 sync low", int'(sync_o), 0);
      chk("R2 early", int'(early_o), (k == 9) ? 1 : 0);
    end
    step();
    chk("R3 wrap count", int'(count_o), 0);
    chk("R3 sync high", int'(sync_o), 1);
    step();
    chk("R3 one-cycle sync", int'(sync_o), 0);
    chk("R4 after wrap", int'(count_o), 1);
  endtask

  task automatic t_load();
    // count is 1 here; offer the first beat
    cfg_match_i = {W'(exp_m[2]), W'(exp_m[1]), W'(exp_m[0])};
    cfg_en_hi_i = exp_hi_en;
    cfg_en_lo_i = exp_lo_en;
    cfg_valid_i = 1'b1;
    chk("R5 ready before", int'(cfg_ready_o), 1);
    step();
    cfg_valid_i = 1'b0;
    chk("R5 ready low after take", int'(cfg_ready_o), 0);
    chk("R6 no mid-period change", int'(pwm_hi_o), 0);
    // offer a second beat while the slot is full
    cfg_match_i = {W'(7), W'(7), W'(7)};
    cfg_en_hi_i = 3'b000;
    cfg_en_lo_i = 3'b010;
    cfg_valid_i = 1'b1;
    step();
    cfg_valid_i = 1'b0;
    chk("R7 still not ready", int'(cfg_ready_o), 0);
    repeat (6) step();
    chk("R2 early at 9", int'(early_o), 1);
    chk("R6 old set before boundary", int'(pwm_lo_o), 0);
    step();
    chk("R3 sync on reload", int'(sync_o), 1);
    chk("R5 ready after move", int'(cfg_ready_o), 1);
    for (int k = 0; k < 10; k++) begin
      logic [N-1:0] eh, el;
      for (int p = 0; p < N; p++) begin
        eh[p] = exp_hi_en[p] && (k < exp_m[p]);
        el[p] = exp_lo_en[p] && (k >= exp_m[p]);
      end
      chk("R8 R6 R7 hi", int'(pwm_hi_o), int'(eh));
      chk("R8 R7 lo", int'(pwm_lo_o), int'(el));
      step();
    end
    chk("R3 back to zero", int'(count_o), 0);
  endtask

  task automatic t_shrink();
    repeat (7) step();
    period_i = W'(5);
    #1;
    chk("R10 early at once", int'(early_o), 1);
    step();
    chk("R10 wrapped", int'(count_o), 0);
    chk("R10 sync", int'(sync_o), 1);
    repeat (4) step();
    chk("R2 new period early", int'(early_o), 1);
    step();
    chk("R3 new period wrap", int'(count_o), 0);
  endtask

  task automatic t_full();
    int n = 0;
    period_i = '0;
    #1;
    while (!early_o && n < 3000) begin
      step();
      n++;
    end
    chk("R9 steps to early", n, 2047);
    chk("R9 last count", int'(count_o), 2047);
    step();
    chk("R9 wrap", int'(count_o), 0);
    chk("R9 sync", int'(sync_o), 1);
  endtask

  initial begin
    rst_ni      = 1'b0;
    period_i    = W'(10);
    cfg_valid_i = 1'b0;
    cfg_match_i = '0;
    cfg_en_hi_i = '0;
    cfg_en_lo_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_count();
    t_load();
    t_shrink();
    t_full();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule